// File: doc/BRIEF.md
# Serial Channel Interrupt Controller

This block decides when one serial communications channel asks the processor for attention. It takes single-cycle event strobes from three sources. The receiver reports a character together with overrun, parity and framing flags. The transmitter reports that its buffer is empty, that a new character was loaded, and that a CRC has finished going out. A third source reports external or status changes. Plain configuration inputs choose one of four receive interrupt modes, enable the transmit and external/status interrupts, and decide whether a parity error counts as a special condition.

Each source keeps a pending bit. A fixed priority network combines the pending bits with the in-service bits and with a daisy-chain enable-in to produce one interrupt request and one enable-out. Software drives the block through a 3-bit command code that is qualified by a valid strobe. The commands re-arm first-character reception, clear the external pending bit, disarm the transmit interrupt, reset the receive errors and retire the highest in-service level.

When a character carries a special condition in the first-character or special-only receive modes, the block raises `rx_hold`. This tells the receive FIFO to keep that character at its output until an error-reset command arrives. If the command arrives before the held character has been read, the block pulses `rx_drop`.

All inputs are level or single-cycle strobes with no back-pressure. The block always accepts an event in the cycle it is presented, so it has no valid/ready handshake. Pending, in-service, error and hold state is registered and becomes visible the cycle after the event that changes it. `irq` and `ien_out` are combinational from that state and from `ien_in`.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset, `pend`, `ius`, `rx_err`, `rx_hold`, `rx_drop` and `irq` are all 0, and first-character reception is armed.
- R2: On a received character, the receive pending bit `pend[0]` is set according to `cfg_rx_mode`: 2'b00 never; 2'b01 on a special condition, or on a plain character while armed; 2'b10 on every character; 2'b11 on a special condition only.
- R3: A special condition is an overrun or a framing error. A parity error is also a special condition when `cfg_par_special` is 1. Every error flag is latched sticky into `rx_err` (bit 0 overrun, bit 1 parity, bit 2 framing), whatever the mode.
- R4: In mode 2'b01, only the first plain character after arming sets `pend[0]`. Command 3'b001 re-arms reception.
- R5: In modes 2'b01 and 2'b11, a special-condition character sets `rx_hold`. A read (`rx_read_stb`) does not release it. Command 3'b110 (error reset) clears `rx_hold`, `rx_err` and the held pending bit. Otherwise `pend[0]` clears on a read.
- R6: `rx_drop` pulses for one cycle when an error reset releases a held character that was never read.
- R7: `tx_empty_stb` sets `pend[1]` only when `cfg_tx_en` is 1. Command 3'b101 clears `pend[1]` and blocks further sets until `tx_load_stb` or `tx_crc_done_stb`. `tx_load_stb` also clears `pend[1]`.
- R8: `ext_stb` sets `pend[2]` only when `cfg_ext_en` is 1. Command 3'b010 clears it.
- R9: Priority is receive (index 0) highest, then transmit (1), then external (2). `irq` is high only when `ien_in` is high and some enabled pending source has no in-service bit set at its own level or higher.
- R10: `iack_stb` while `irq` is high sets the in-service bit of the highest unblocked requesting source. `ien_out` is low while any in-service bit is set or `ien_in` is low.
- R11: Command 3'b111 clears only the highest-priority (lowest index) set in-service bit. Any other code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_mode | input | 2 | Receive interrupt mode |
| cfg_par_special | input | 1 | Parity error counts as special condition |
| cfg_tx_en | input | 1 | Transmit interrupt enable |
| cfg_ext_en | input | 1 | External/status interrupt enable |
| rx_char_stb | input | 1 | Character received |
| rx_ovr | input | 1 | Overrun flag with character |
| rx_par | input | 1 | Parity error flag with character |
| rx_frm | input | 1 | Framing error flag with character |
| rx_read_stb | input | 1 | FIFO output character read |
| tx_empty_stb | input | 1 | Transmit buffer became empty |
| tx_load_stb | input | 1 | Character written to transmit buffer |
| tx_crc_done_stb | input | 1 | CRC transmission completed |
| ext_stb | input | 1 | External/status change |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| iack_stb | input | 1 | Interrupt acknowledge |
| ien_in | input | 1 | Daisy-chain enable in |
| irq | output | 1 | Interrupt request (active high) |
| ien_out | output | 1 | Daisy-chain enable out |
| pend | output | 3 | Pending bits {ext, tx, rx} |
| ius | output | 3 | In-service bits {ext, tx, rx} |
| rx_err | output | 3 | Latched errors {framing, parity, overrun} |
| rx_hold | output | 1 | Hold receive FIFO output |
| rx_drop | output | 1 | Held character discarded |

## Verification
The receive function is driven by a table. The table pairs each of the four modes with clean, overrun, parity and framing characters, with the parity-special control both on and off. This separates mode decoding from the special-condition test and from hold generation. Directed sequences then check the following:
- first-character arming against later plain characters;
- an error reset after a read against one before a read, which is the only case that gives a drop pulse;
- transmit disarming lifted by a buffer load against one lifted by CRC completion;
- priority across nested acknowledges, which shows that retiring the top in-service level unblocks only the sources below it.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NSRC = 3;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_EXT = 2;

  typedef enum logic [1:0] {
    RXM_OFF   = 2'b00,
    RXM_FIRST = 2'b01,
    RXM_ALL   = 2'b10,
    RXM_SPEC  = 2'b11
  } rx_mode_e;

  typedef enum logic [2:0] {
    CMD_ARM_RX  = 3'b001,
    CMD_RST_EXT = 3'b010,
    CMD_RST_TX  = 3'b101,
    CMD_ERR_RST = 3'b110,
    CMD_RST_IUS = 3'b111
  } cmd_e;
endpackage

// File: rtl/chan_rx_src.sv
module chan_rx_src
  import chan_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       par_special,
  input  logic       char_stb,
  input  logic       ovr,
  input  logic       par,
  input  logic       frm,
  input  logic       read_stb,
  input  logic       cmd_arm,
  input  logic       cmd_err,
  output logic       pend,
  output logic       hold,
  output logic [2:0] err,
  output logic       drop
);
  logic armed, held_read;
  logic special, want_pend, want_hold;

  always_comb begin
    special   = ovr | frm | (par & par_special);
    want_hold = special & ((mode == RXM_FIRST) | (mode == RXM_SPEC));
    unique case (rx_mode_e'(mode))
      RXM_OFF:   want_pend = 1'b0;
      RXM_FIRST: want_pend = special | armed;
      RXM_ALL:   want_pend = 1'b1;
      default:   want_pend = special;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold      <= 1'b0;
      err       <= '0;
      drop      <= 1'b0;
      armed     <= 1'b1;
      held_read <= 1'b0;
    end else begin
      drop <= 1'b0;
      if (cmd_err) begin
        err       <= '0;
        hold      <= 1'b0;
        held_read <= 1'b0;
        drop      <= hold & ~held_read;
        if (hold) pend <= 1'b0;
      end else begin
        if (read_stb) begin
          if (hold) held_read <= 1'b1;
          else      pend      <= 1'b0;
        end
        if (char_stb) begin
          err <= err | {frm, par, ovr};
          if (want_pend) pend <= 1'b1;
          if (want_hold) begin
            hold      <= 1'b1;
            held_read <= 1'b0;
          end
          if (mode == RXM_FIRST && !special) armed <= 1'b0;
        end
      end
      if (cmd_arm) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_tx_src.sv
module chan_tx_src (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic empty_stb,
  input  logic load_stb,
  input  logic crc_done_stb,
  input  logic cmd_rst,
  output logic pend
);
  logic disarmed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      disarmed <= 1'b0;
    end else if (cmd_rst) begin
      pend     <= 1'b0;
      disarmed <= 1'b1;
    end else begin
      if (load_stb) begin
        pend     <= 1'b0;
        disarmed <= 1'b0;
      end
      if (crc_done_stb) disarmed <= 1'b0;
      if (empty_stb && en && !disarmed) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_prio_net.sv
module chan_prio_net #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         ien_in,
  input  logic         iack_stb,
  input  logic         rst_top,
  output logic         irq,
  output logic         ien_out,
  output logic [N-1:0] ius
);
  logic [N-1:0] blocked, open_req, grant;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_blk
      assign blocked[gi] = |ius[gi:0];
    end
  endgenerate

  assign open_req = req & ~blocked;
  assign grant    = open_req & (~open_req + 1'b1);
  assign irq      = ien_in & (|open_req);
  assign ien_out  = ien_in & ~(|ius);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ius <= '0;
    end else if (rst_top) begin
      ius <= ius & (ius - 1'b1);
    end else if (iack_stb && irq) begin
      ius <= ius | grant;
    end
  end
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_rx_mode,
  input  logic            cfg_par_special,
  input  logic            cfg_tx_en,
  input  logic            cfg_ext_en,
  input  logic            rx_char_stb,
  input  logic            rx_ovr,
  input  logic            rx_par,
  input  logic            rx_frm,
  input  logic            rx_read_stb,
  input  logic            tx_empty_stb,
  input  logic            tx_load_stb,
  input  logic            tx_crc_done_stb,
  input  logic            ext_stb,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_code,
  input  logic            iack_stb,
  input  logic            ien_in,
  output logic            irq,
  output logic            ien_out,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] ius,
  output logic [2:0]      rx_err,
  output logic            rx_hold,
  output logic            rx_drop
);
  logic c_arm, c_ext, c_tx, c_err, c_ius;
  logic ext_pend;
  logic [NSRC-1:0] en_mask;

  assign c_arm = cmd_valid && cmd_code == CMD_ARM_RX;
  assign c_ext = cmd_valid && cmd_code == CMD_RST_EXT;
  assign c_tx  = cmd_valid && cmd_code == CMD_RST_TX;
  assign c_err = cmd_valid && cmd_code == CMD_ERR_RST;
  assign c_ius = cmd_valid && cmd_code == CMD_RST_IUS;

  chan_rx_src u_rx (
    .clk(clk), .rst_n(rst_n), .mode(cfg_rx_mode), .par_special(cfg_par_special),
    .char_stb(rx_char_stb), .ovr(rx_ovr), .par(rx_par), .frm(rx_frm),
    .read_stb(rx_read_stb), .cmd_arm(c_arm), .cmd_err(c_err),
    .pend(pend[SRC_RX]), .hold(rx_hold), .err(rx_err), .drop(rx_drop)
  );

  chan_tx_src u_tx (
    .clk(clk), .rst_n(rst_n), .en(cfg_tx_en), .empty_stb(tx_empty_stb),
    .load_stb(tx_load_stb), .crc_done_stb(tx_crc_done_stb), .cmd_rst(c_tx),
    .pend(pend[SRC_TX])
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   ext_pend <= 1'b0;
    else if (c_ext)               ext_pend <= 1'b0;
    else if (ext_stb && cfg_ext_en) ext_pend <= 1'b1;
  end
  assign pend[SRC_EXT] = ext_pend;

  assign en_mask[SRC_RX]  = cfg_rx_mode != RXM_OFF;
  assign en_mask[SRC_TX]  = cfg_tx_en;
  assign en_mask[SRC_EXT] = cfg_ext_en;

  chan_prio_net #(.N(NSRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(pend & en_mask), .ien_in(ien_in),
    .iack_stb(iack_stb), .rst_top(c_ius), .irq(irq), .ien_out(ien_out), .ius(ius)
  );
endmodule

// File: rtl/chan_irq_ctrl_chk.sv
module chan_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_rx_mode,
  input logic       rx_char_stb,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       iack_stb,
  input logic       ien_in,
  input logic       irq,
  input logic       ien_out,
  input logic [2:0] pend,
  input logic [2:0] ius,
  input logic [2:0] rx_err,
  input logic       rx_hold,
  input logic       rx_drop
);
  // R9: no request without the daisy-chain enable
  a_r9_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_in);
  // R10: enable-out is low while any level is in service
  a_r10_ien_out_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius) |-> !ien_out);
  // R10/R11: in-service bits change only by acknowledge or command
  a_r10_ius_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_stb && !cmd_valid) |=> $stable(ius));
  // R11: reset-highest retires exactly one level
  a_r11_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'b111 && ius != 3'b000) |=>
      $countones(ius) == $countones($past(ius)) - 1);
  // R5: hold only appears in first-character or special-only modes
  a_r5_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_hold) |-> ($past(cfg_rx_mode) == 2'b01 || $past(cfg_rx_mode) == 2'b11));
  // R5: error reset clears errors and hold
  a_r5_err_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'b110 && !rx_char_stb) |=> (rx_err == 3'b000 && !rx_hold));
  // R7: disarm command clears transmit pending
  a_r7_tx_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'b101) |=> !pend[1]);
  // R6: a drop is never reported twice in a row
  a_r6_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> !rx_drop);
endmodule

bind chan_irq_ctrl chan_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rx_mode(cfg_rx_mode), .rx_char_stb(rx_char_stb),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .iack_stb(iack_stb), .ien_in(ien_in),
  .irq(irq), .ien_out(ien_out), .pend(pend), .ius(ius), .rx_err(rx_err),
  .rx_hold(rx_hold), .rx_drop(rx_drop)
);

// File: tb/sim_chan_irq_ctrl.sv
module sim_chan_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_rx_mode = 2'b00;
  logic cfg_par_special = 1'b0, cfg_tx_en = 1'b0, cfg_ext_en = 1'b0;
  logic rx_char_stb = 0, rx_ovr = 0, rx_par = 0, rx_frm = 0, rx_read_stb = 0;
  logic tx_empty_stb = 0, tx_load_stb = 0, tx_crc_done_stb = 0, ext_stb = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_code = 3'b000;
  logic iack_stb = 0, ien_in = 1'b1;
  logic irq, ien_out, rx_hold, rx_drop;
  logic [2:0] pend, ius, rx_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  chan_irq_ctrl u0 (.*);

  // {mode[1:0], ovr, par, frm, par_special, exp_pend, exp_hold}
  localparam logic [7:0] VEC [10] = '{
    8'b00_000_0_00, 8'b00_100_0_00, 8'b01_000_0_10, 8'b01_001_0_11,
    8'b10_000_0_10, 8'b10_100_0_10, 8'b11_000_0_00, 8'b11_010_0_00,
    8'b11_010_1_11, 8'b01_010_0_10 };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic rx_char(logic o, logic p, logic f);
    @(negedge clk) begin rx_char_stb = 1; rx_ovr = o; rx_par = p; rx_frm = f; end
    @(negedge clk) begin rx_char_stb = 0; rx_ovr = 0; rx_par = 0; rx_frm = 0; end
  endtask

  task automatic cmd(logic [2:0] c);
    @(negedge clk) begin cmd_valid = 1; cmd_code = c; end
    @(negedge clk) cmd_valid = 0;
  endtask

  // 0 read, 1 tx empty, 2 tx load, 3 crc done, 4 ext, 5 iack
  task automatic pulse(int which);
    @(negedge clk) case (which)
      0: rx_read_stb = 1; 1: tx_empty_stb = 1; 2: tx_load_stb = 1;
      3: tx_crc_done_stb = 1; 4: ext_stb = 1; default: iack_stb = 1;
    endcase
    @(negedge clk) begin
      rx_read_stb = 0; tx_empty_stb = 0; tx_load_stb = 0;
      tx_crc_done_stb = 0; ext_stb = 0; iack_stb = 0;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pend", pend, 0); chk("R1 ius", ius, 0); chk("R1 irq", irq, 0);
    chk("R1 err", rx_err, 0); chk("R1 hold", rx_hold, 0); chk("R1 drop", rx_drop, 0);
    chk("R1 ien_out", ien_out, 1);

    // R2/R3: receive mode table
    foreach (VEC[i]) begin
      do_reset();
      cfg_rx_mode = VEC[i][7:6]; cfg_par_special = VEC[i][2];
      rx_char(VEC[i][5], VEC[i][4], VEC[i][3]);
      chk("R2 rx pend", pend[0], VEC[i][1]);
      chk("R5 hold", rx_hold, VEC[i][0]);
      chk("R3 err", rx_err, {VEC[i][3], VEC[i][4], VEC[i][5]});
    end
    cfg_par_special = 0;

    // R4: first-character arming
    do_reset(); cfg_rx_mode = 2'b01;
    rx_char(0,0,0); chk("R4 first", pend[0], 1);
    pulse(0); chk("R5 read clears", pend[0], 0);
    rx_char(0,0,0); chk("R4 second", pend[0], 0);
    cmd(3'b001); rx_char(0,0,0); chk("R4 rearm", pend[0], 1);

    // R5/R6: hold, read, error reset
    do_reset(); cfg_rx_mode = 2'b11;
    rx_char(1,0,0); pulse(0);
    chk("R5 held after read", rx_hold, 1); chk("R5 pend held", pend[0], 1);
    cmd(3'b110);
    chk("R5 released", rx_hold, 0); chk("R5 err cleared", rx_err, 0);
    chk("R5 pend cleared", pend[0], 0); chk("R6 no drop", rx_drop, 0);
    rx_char(0,0,1); cmd(3'b110);
    chk("R6 drop", rx_drop, 1);
    @(negedge clk) chk("R6 drop one cycle", rx_drop, 0);
    cmd(3'b000); chk("R11 other code", {pend, ius}, 0);

    // R7: transmit
    do_reset(); cfg_rx_mode = 2'b00; cfg_tx_en = 1;
    pulse(1); chk("R7 empty", pend[1], 1);
    cmd(3'b101); chk("R7 disarm", pend[1], 0);
    pulse(1); chk("R7 blocked", pend[1], 0);
    pulse(2); pulse(1); chk("R7 load rearms", pend[1], 1);
    cmd(3'b101); pulse(3); pulse(1); chk("R7 crc rearms", pend[1], 1);
    pulse(2); cfg_tx_en = 0; pulse(1); chk("R7 disabled", pend[1], 0);

    // R8: external
    pulse(4); chk("R8 disabled", pend[2], 0);
    cfg_ext_en = 1; pulse(4); chk("R8 set", pend[2], 1);
    cmd(3'b010); chk("R8 cleared", pend[2], 0);

    // R9/R10/R11: priority
    do_reset(); cfg_tx_en = 1; cfg_ext_en = 1; cfg_rx_mode = 2'b10;
    pulse(1); pulse(4); chk("R9 irq", irq, 1);
    ien_in = 0; #1 chk("R9 ien_in low", irq, 0); chk("R10 ien_out", ien_out, 0);
    @(negedge clk) ien_in = 1;
    pulse(5); chk("R10 ius tx", ius, 3'b010);
    chk("R9 blocked", irq, 0); chk("R10 ien_out low", ien_out, 0);
    rx_char(0,0,0); chk("R9 rx preempts", irq, 1);
    pulse(5); chk("R10 ius nest", ius, 3'b011);
    cmd(3'b111); chk("R11 top retired", ius, 3'b010);
    pulse(0); chk("R9 still blocked", irq, 0);
    cmd(3'b111); chk("R11 all retired", ius, 0);
    chk("R9 tx again", irq, 1); chk("R10 ien_out back", ien_out, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule